// File: doc/BRIEF.md
# Edge-Sensing GPIO Controller

This block is a 32-pin general-purpose I/O controller addressed through a simple register bus. Each pin can be an input or an output. An output pin can be driven push-pull or open-drain. The block watches every pad for level changes and latches qualifying edges into a pending-event register. Events that are enabled by a mask register are combined into one interrupt line.

Software programs the pins through seven 32-bit registers. All of them use the same bit numbering: pin p lives at bit (31 − p), so pin 0 is the most significant bit. The pad-side vectors `pad_in`, `pad_out` and `pad_oe` use this numbering too.

Pad levels pass through a two-flop synchronizer before the block reads them or detects edges on them. A parameter picks how edges are qualified. In the compact mode, each pin has one control bit that selects either falling edges only or both edges. In the wide mode, each pin has a two-bit sense field, and these fields are spread over two control registers.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is all zero and `irq` is low.
- R2: The registers at offsets 0x00 (direction), 0x04 (open-drain), 0x10 (mask), 0x14 (sense A) and 0x18 (sense B) read back the last value written to them. The new value is visible from the cycle after the write.
- R3: For a direction bit of 1 (output) with open-drain 0, `pad_oe` is 1 and `pad_out` equals the data bit. For a direction bit of 0 (input), `pad_oe` is 0.
- R4: For an output pin with open-drain 1, `pad_oe` is 1 only while the data bit is 0, and `pad_out` is 0 for that pin.
- R5: Reading the data register (0x08) returns the written value on output pins and the synchronized pad level on input pins.
- R6: In compact mode, a sense-A bit of 0 latches both rising and falling edges into the event register (0x0C). This happens whether or not the pin is masked.
- R7: In compact mode, a sense-A bit of 1 latches only falling edges. Rising edges leave the event bit at 0.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly when (event AND mask) is non-zero.
- R10: In wide mode, pin p uses sense A for pins 0–15 and sense B for pins 16–31. Its field sits at bits [(15 − p mod 16)·2 +: 2]. The code 2'b10 latches falling edges only, 2'b01 rising edges only, and 2'b00 both edges.
- R11: If an edge is latched in the same cycle that a write-1 clear targets the same event bit, the bit ends up set.
- R12: A pad change applied between clock edges shows in the event register after the third rising clock edge, and not after the second.
- R13: In wide mode, the sense code 2'b11 latches no edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Pad levels, pin p at bit 31−p |
| pad_out | output | 32 | Value driven to the pads |
| pad_oe | output | 32 | Output enable per pad |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker asserts on every cycle the following: `pad_oe` stays off on input pins, an open-drain pin is released while its data bit is 1, output-pin data reads back exactly, a masked-off event never raises `irq`, write-1 clears take effect, and a detected edge always lands in the event register even when a clear hits it at the same time. Other behaviour needs stimulus and can only be shown by the bench's scenarios. This covers the three-edge latency from pad to event, the per-mode edge qualification, the field placement across the two sense registers in wide mode, and the disabled code 2'b11.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int unsigned GPIO_W = 32;

    localparam logic [7:0] OFF_DIR  = 8'h00;
    localparam logic [7:0] OFF_ODRN = 8'h04;
    localparam logic [7:0] OFF_DATA = 8'h08;
    localparam logic [7:0] OFF_EVT  = 8'h0C;
    localparam logic [7:0] OFF_MASK = 8'h10;
    localparam logic [7:0] OFF_SNSA = 8'h14;
    localparam logic [7:0] OFF_SNSB = 8'h18;

    typedef struct packed {
        logic [GPIO_W-1:0] dir;
        logic [GPIO_W-1:0] odrn;
        logic [GPIO_W-1:0] data;
        logic [GPIO_W-1:0] evt;
        logic [GPIO_W-1:0] mask;
        logic [GPIO_W-1:0] snsa;
        logic [GPIO_W-1:0] snsb;
    } gpio_regs_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] prev_q, prev_d;

    always_comb begin
        stg_d[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
        prev_d = stg_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
            prev_q <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
            prev_q <= prev_d;
        end
    end

    assign lvl      = stg_q[STAGES-1];
    assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense #(
    parameter int unsigned W    = 32,
    parameter bit          WIDE = 1'b0
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_prev,
    input  logic [W-1:0] ctl_a,
    input  logic [W-1:0] ctl_b,
    output logic [W-1:0] hit
);
    localparam int unsigned HALF = W / 2;

    logic [W-1:0] rise, fall;
    assign rise = lvl & ~lvl_prev;
    assign fall = ~lvl & lvl_prev;

    if (WIDE) begin : g_wide
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [1:0] fld;
            if (b >= HALF) begin : g_hi
                assign fld = ctl_a[(b-HALF)*2 +: 2];
            end else begin : g_lo
                assign fld = ctl_b[b*2 +: 2];
            end
            always_comb begin
                unique case (fld)
                    2'b00:   hit[b] = rise[b] | fall[b];
                    2'b01:   hit[b] = rise[b];
                    2'b10:   hit[b] = fall[b];
                    default: hit[b] = 1'b0;
                endcase
            end
        end
    end else begin : g_compact
        logic unused_ctl_b;
        assign unused_ctl_b = ^ctl_b;
        assign hit = fall | (rise & ~ctl_a);
    end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] odrn,
    input  logic [W-1:0] data,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar b = 0; b < W; b++) begin : g_pin
        always_comb begin
            if (odrn[b]) begin
                pad_out[b] = 1'b0;
                pad_oe[b]  = dir[b] & ~data[b];
            end else begin
                pad_out[b] = data[b];
                pad_oe[b]  = dir[b];
            end
        end
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter bit          SENSE_WIDE = 1'b0,
    parameter int unsigned SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pad_in,
    output logic [31:0]       pad_out,
    output logic [31:0]       pad_oe,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_ODRN = ADDR_W'(OFF_ODRN);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFF_EVT);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_SNSA = ADDR_W'(OFF_SNSA);
    localparam logic [ADDR_W-1:0] A_SNSB = ADDR_W'(OFF_SNSB);

    gpio_regs_t r_q, r_d;

    logic [GPIO_W-1:0] lvl, lvl_prev, edge_hit;
    logic [GPIO_W-1:0] dir_q, odrn_q, data_q, evt_q, mask_q;

    assign dir_q  = r_q.dir;
    assign odrn_q = r_q.odrn;
    assign data_q = r_q.data;
    assign evt_q  = r_q.evt;
    assign mask_q = r_q.mask;

    gpio_in_sync #(.W(GPIO_W), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (pad_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    gpio_edge_sense #(.W(GPIO_W), .WIDE(SENSE_WIDE)) u_sense (
        .lvl      (lvl),
        .lvl_prev (lvl_prev),
        .ctl_a    (r_q.snsa),
        .ctl_b    (r_q.snsb),
        .hit      (edge_hit)
    );

    gpio_pad_drive #(.W(GPIO_W)) u_drive (
        .dir     (dir_q),
        .odrn    (odrn_q),
        .data    (data_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // next-state: register writes, then event latching (set wins over clear)
    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            unique case (bus_addr)
                A_DIR:   r_d.dir  = bus_wdata;
                A_ODRN:  r_d.odrn = bus_wdata;
                A_DATA:  r_d.data = bus_wdata;
                A_EVT:   r_d.evt  = r_q.evt & ~bus_wdata;
                A_MASK:  r_d.mask = bus_wdata;
                A_SNSA:  r_d.snsa = bus_wdata;
                A_SNSB:  r_d.snsb = bus_wdata;
                default: ;
            endcase
        end
        r_d.evt = r_d.evt | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // read mux
    always_comb begin
        unique case (bus_addr)
            A_DIR:   bus_rdata = r_q.dir;
            A_ODRN:  bus_rdata = r_q.odrn;
            A_DATA:  bus_rdata = (r_q.data & r_q.dir) | (lvl & ~r_q.dir);
            A_EVT:   bus_rdata = r_q.evt;
            A_MASK:  bus_rdata = r_q.mask;
            A_SNSA:  bus_rdata = r_q.snsa;
            A_SNSB:  bus_rdata = r_q.snsb;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = |(r_q.evt & r_q.mask);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       pad_oe,
    input logic              irq,
    input logic [31:0]       dir_q,
    input logic [31:0]       odrn_q,
    input logic [31:0]       data_q,
    input logic [31:0]       evt_q,
    input logic [31:0]       mask_q,
    input logic [31:0]       edge_hit
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(8'h0C);

    // R3
    input_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == 32'h0);

    // R4
    odrn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & odrn_q & data_q) == 32'h0);

    // R5
    out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DATA) |-> ((bus_rdata & dir_q) == (data_q & dir_q)));

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 32'h0) |-> !irq);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EVT && ((bus_wdata & ~edge_hit) != 32'h0))
        |=> ((evt_q & $past(bus_wdata & ~edge_hit)) == 32'h0));

    // R11
    hit_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != 32'h0) |=> ((evt_q & $past(edge_hit)) == $past(edge_hit)));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .dir_q     (dir_q),
    .odrn_q    (odrn_q),
    .data_q    (data_q),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .edge_hit  (edge_hit)
);

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] rdata, pad_out, pad_oe;
    logic [31:0] rdata2, pad_out2, pad_oe2;
    logic        irq, irq2;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    gpio_edge_ctrl #(.SENSE_WIDE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    gpio_edge_ctrl #(.SENSE_WIDE(1'b1)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata2), .pad_in(pad_in), .pad_out(pad_out2), .pad_oe(pad_oe2), .irq(irq2)
    );

    function automatic logic [31:0] pin(input int p);
        return 32'h1 << (31 - p);
    endfunction

    function automatic logic [31:0] exp_oe(input logic [31:0] d, o, v);
        return d & ~(o & v);
    endfunction

    function automatic logic [31:0] exp_out(input logic [31:0] o, v);
        return v & ~o;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d2);
        addr = a; wr = 1'b0;
        #1;
        d = rdata; d2 = rdata2;
    endtask

    initial begin
        logic [31:0] v, v2;
        logic [31:0] m_dir, m_odrn, m_data, m_mask, m_snsa, m_snsb, pads;
        logic [7:0] offs [6];
        offs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18};
        void'($urandom(32'd4242));

        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        for (int i = 0; i < 7; i++) begin
            bus_read(8'(i * 4), v, v2);
            check("R1 reg", v, 32'h0);
            check("R1 reg wide", v2, 32'h0);
        end
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // random register traffic with a fixed pad pattern
        pads = $urandom();
        pad_in = pads;
        tick(4);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        m_dir = 0; m_odrn = 0; m_data = 0; m_mask = 0; m_snsa = 0; m_snsb = 0;
        for (int it = 0; it < 60; it++) begin
            int sel;
            logic [31:0] val;
            sel = int'($urandom_range(0, 5));
            val = $urandom();
            if (it == 5) val = 32'hFFFF_FFFF;
            bus_write(offs[sel], val);
            unique case (sel)
                0: m_dir  = val;
                1: m_odrn = val;
                2: m_data = val;
                3: m_mask = val;
                4: m_snsa = val;
                default: m_snsb = val;
            endcase
            bus_read(offs[sel], v, v2);
            if (sel == 2)
                check("R5 data read", v, (m_data & m_dir) | (pads & ~m_dir));
            else
                check("R2 readback", v, val);
            check("R3 R4 pad_oe", pad_oe, exp_oe(m_dir, m_odrn, m_data));
            check("R3 R4 pad_out", pad_out, exp_out(m_odrn, m_data));
        end
        // directed open-drain corner: output, open-drain, data 1 vs 0 on pin 2
        bus_write(8'h00, pin(2));
        bus_write(8'h04, pin(2));
        bus_write(8'h08, pin(2));
        check("R4 released", pad_oe & pin(2), 32'h0);
        bus_write(8'h08, 32'h0);
        check("R4 driven low", pad_oe & pin(2), pin(2));
        check("R4 drives zero", pad_out & pin(2), 32'h0);

        // event tests: all inputs, masked, all sense fields zero
        bus_write(8'h00, 32'h0);
        bus_write(8'h10, 32'h0);
        bus_write(8'h14, 32'h0);
        bus_write(8'h18, 32'h0);
        pad_in = 32'h0;
        tick(4);
        bus_write(8'h0C, 32'hFFFF_FFFF);

        // R12 latency, R6 rising edge while masked
        pad_in = pin(3);
        tick(2);
        bus_read(8'h0C, v, v2);
        check("R12 not yet", v, 32'h0);
        tick(1);
        bus_read(8'h0C, v, v2);
        check("R12 R6 rise latched", v, pin(3));
        check("R10 wide 00 rise", v2, pin(3));
        check("R9 masked irq low", {31'h0, irq}, 32'h0);
        bus_read(8'h08, v, v2);
        check("R5 input level", v, pin(3));
        bus_write(8'h10, pin(3));
        check("R9 irq high", {31'h0, irq}, 32'h1);
        bus_write(8'h0C, 32'h0);
        bus_read(8'h0C, v, v2);
        check("R8 write zero keeps", v, pin(3));
        bus_write(8'h0C, ~pin(3));
        bus_read(8'h0C, v, v2);
        check("R8 other bits keep", v, pin(3));
        bus_write(8'h0C, pin(3));
        bus_read(8'h0C, v, v2);
        check("R8 clear", v, 32'h0);
        check("R9 irq low after clear", {31'h0, irq}, 32'h0);
        bus_write(8'h0C, 32'hFFFF_FFFF);

        // R6 falling edge
        pad_in = 32'h0;
        tick(3);
        bus_read(8'h0C, v, v2);
        check("R6 fall latched", v, pin(3));
        check("R10 wide 00 fall", v2, pin(3));
        bus_write(8'h10, 32'h0);
        bus_write(8'h0C, 32'hFFFF_FFFF);

        // R7 falling only in compact mode
        bus_write(8'h14, pin(3));
        pad_in = pin(3);
        tick(4);
        bus_read(8'h0C, v, v2);
        check("R7 rise ignored", v, 32'h0);
        pad_in = 32'h0;
        tick(3);
        bus_read(8'h0C, v, v2);
        check("R7 fall latched", v, pin(3));
        bus_write(8'h14, 32'h0);
        bus_write(8'h0C, 32'hFFFF_FFFF);

        // R10 R13 wide mode: pin 3 rise-only (sense A bits 25:24),
        // pin 5 code 11 (sense A bits 21:20), pin 20 fall-only (sense B bits 23:22)
        bus_write(8'h14, (32'h1 << 24) | (32'h3 << 20));
        bus_write(8'h18, 32'h2 << 22);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        pad_in = pin(3) | pin(5) | pin(20);
        tick(3);
        bus_read(8'h0C, v, v2);
        check("R10 R13 wide rise", v2, pin(3));
        bus_write(8'h0C, 32'hFFFF_FFFF);
        pad_in = 32'h0;
        tick(3);
        bus_read(8'h0C, v, v2);
        check("R10 R13 wide fall", v2, pin(20));
        bus_write(8'h14, 32'h0);
        bus_write(8'h18, 32'h0);
        tick(2);
        bus_write(8'h0C, 32'hFFFF_FFFF);

        // R11 set wins over simultaneous clear
        pad_in = pin(3);
        tick(2);
        addr = 8'h0C; wr = 1'b1; wdata = pin(3);
        @(negedge clk);
        wr = 1'b0;
        bus_read(8'h0C, v, v2);
        check("R11 set wins", v, pin(3));
        bus_write(8'h0C, pin(3));
        bus_read(8'h0C, v, v2);
        check("R11 later clear", v, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule